// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm timer. Software writes a number of seconds into a load register. While the run bit is set, the counter steps down by one on each one-second tick. When the count moves from one to zero, a sticky pending flag is set. The counter then holds at zero until software loads a new interval.

The pending flag drives two outputs:
- an interrupt line, gated by an interrupt-enable bit;
- a wakeup line, gated by a separate wakeup-enable bit.

Software clears the flag by writing one to its bit. Writing zero into the load register cancels a countdown in progress without raising the flag. The usual sequence for rearming is to cancel with a zero, then load the new interval.

A second channel sits beside the countdown. It has its own run bit, interrupt-enable bit and write-one-to-clear pending bit. Its match condition is an external input (`wall_match`), so that software can enable, observe, clear and disable it. Register access is a single-cycle write strobe with a combinational read mux.

Top module: `cd_alarm`

## Requirements
- R1: After synchronous reset, every register reads 0, and `cnt_irq`, `cnt_wake` and `wall_irq` are low.
- R2: A write to address 0 (load) sets the remaining count, read at address 1, to the written 32-bit value on the next clock. Address 0 reads back the last loaded value.
- R3: The remaining count falls by exactly one per cycle in which `tick` is high and the run bit (address 2, bit 0) is 1. It is unchanged by ticks while the run bit is 0.
- R4: When a tick takes the count from 1 to 0, the countdown pending flag (address 4, bit 0) is set once. The count then stays at 0 under further ticks, and the flag is not set again.
- R5: Loading 0 clears a running countdown to 0 without setting the pending flag.
- R6: Writing 1 to bit 0 of address 4 clears the countdown pending flag, and writing 0 leaves it unchanged. If a clear and a new expiry fall in the same cycle, the flag stays set.
- R7: `cnt_irq` is high exactly when the pending flag and the interrupt-enable bit (address 3, bit 0) are both 1.
- R8: `cnt_wake` is high exactly when the pending flag and the wakeup-enable bit (address 5, bit 0) are both 1.
- R9: The wall channel's pending flag (address 8, bit 0) is set by `wall_match` only while its run bit (address 6, bit 0) is 1. Writing 1 to bit 0 of address 8 clears it. `wall_irq` equals that flag ANDed with address 7, bit 0.
- R10: Writes to the remaining-count address 1 have no effect, and unmapped addresses read 0.
- R11: A load in the same cycle as a counting tick takes priority: the count becomes the loaded value, not that value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wall_match | input | 1 | Match event for the second alarm channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| cnt_irq | output | 1 | Countdown interrupt |
| cnt_wake | output | 1 | Countdown wakeup request |
| wall_irq | output | 1 | Second channel interrupt |

## Verification
A wrong count shows up directly at address 1 on the cycle after the tick or load that caused it. An off-by-one in the expiry detection moves the rise of `cnt_irq` one tick early or late. A pending flag that fails to stick, or that re-arms, shows up as `cnt_irq`/`cnt_wake` dropping after extra ticks, or rising again after a clear. The collision cases, where load meets tick and clear meets expiry, are driven in the same cycle. Because of that, a wrong priority is visible on the very next register read.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int NUM_CH = 2;
    localparam int CH_CNT  = 0;
    localparam int CH_WALL = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_LOAD     = 4'd0,
        A_REMAIN   = 4'd1,
        A_RUN      = 4'd2,
        A_IEN      = 4'd3,
        A_PEND     = 4'd4,
        A_WAKE     = 4'd5,
        A_WALL_RUN = 4'd6,
        A_WALL_IEN = 4'd7,
        A_WALL_PND = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic ien;
        logic wake_en;
        logic wall_run;
        logic wall_ien;
    } ctrl_t;

    typedef struct packed {
        logic              load;
        logic [DATA_W-1:0] value;
    } load_req_t;

    function automatic logic is_hit(input logic wr, input logic [ADDR_W-1:0] addr,
                                    input reg_sel_e sel);
        return wr && (addr == sel);
    endfunction

    function automatic logic [DATA_W-1:0] flag_word(input logic b);
        return {{(DATA_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/cd_countdown.sv
module cd_countdown
    import alarm_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         step;

    assign step     = tick_i && run_i && (cnt_q != '0);
    assign expire_o = step && (cnt_q == ONE) && !ld_i;
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // R3
    tick_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && run_i && !ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_i && !(tick_i && run_i)) |=> $stable(cnt_q));

    // R4
    zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !ld_i) |=> (cnt_q == '0));

endmodule

// File: rtl/cd_pending.sv
module cd_pending (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pend_q);

    // R6
    set_first_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pend_q);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(pend_q));

endmodule

// File: rtl/cd_regs.sv
module cd_regs
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] remain_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic [DATA_W-1:0] reg_rdata,
    output ctrl_t             ctrl_o,
    output load_req_t         load_o,
    output logic [NUM_CH-1:0] clr_o
);

    logic [DATA_W-1:0] last_load_q;
    ctrl_t             ctrl_q;

    assign load_o.load  = is_hit(reg_wr, reg_addr, A_LOAD);
    assign load_o.value = reg_wdata;

    assign clr_o[CH_CNT]  = is_hit(reg_wr, reg_addr, A_PEND) && reg_wdata[0];
    assign clr_o[CH_WALL] = is_hit(reg_wr, reg_addr, A_WALL_PND) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_load_q <= '0;
            ctrl_q      <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_LOAD:     last_load_q     <= reg_wdata;
                A_RUN:      ctrl_q.run      <= reg_wdata[0];
                A_IEN:      ctrl_q.ien      <= reg_wdata[0];
                A_WAKE:     ctrl_q.wake_en  <= reg_wdata[0];
                A_WALL_RUN: ctrl_q.wall_run <= reg_wdata[0];
                A_WALL_IEN: ctrl_q.wall_ien <= reg_wdata[0];
                default:    ;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;

    always_comb begin
        case (reg_addr)
            A_LOAD:     reg_rdata = last_load_q;
            A_REMAIN:   reg_rdata = remain_i;
            A_RUN:      reg_rdata = flag_word(ctrl_q.run);
            A_IEN:      reg_rdata = flag_word(ctrl_q.ien);
            A_PEND:     reg_rdata = flag_word(pend_i[CH_CNT]);
            A_WAKE:     reg_rdata = flag_word(ctrl_q.wake_en);
            A_WALL_RUN: reg_rdata = flag_word(ctrl_q.wall_run);
            A_WALL_IEN: reg_rdata = flag_word(ctrl_q.wall_ien);
            A_WALL_PND: reg_rdata = flag_word(pend_i[CH_WALL]);
            default:    reg_rdata = '0;
        endcase
    end

    // R2
    load_echo_chk: assert property (@(posedge clk) disable iff (rst)
        is_hit(reg_wr, reg_addr, A_LOAD) |=> (last_load_q == $past(reg_wdata)));

endmodule

// File: rtl/cd_alarm.sv
module cd_alarm
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wall_match,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cnt_irq,
    output logic              cnt_wake,
    output logic              wall_irq
);

    ctrl_t             ctrl;
    load_req_t         load_req;
    logic [DATA_W-1:0] remain;
    logic              expire;
    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] pend_v;

    cd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .remain_i  (remain),
        .pend_i    (pend_v),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .load_o    (load_req),
        .clr_o     (clr_v)
    );

    cd_countdown #(.W(DATA_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .run_i    (ctrl.run),
        .ld_i     (load_req.load),
        .ld_val_i (load_req.value),
        .cnt_o    (remain),
        .expire_o (expire)
    );

    assign set_v[CH_CNT]  = expire;
    assign set_v[CH_WALL] = wall_match && ctrl.wall_run;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
        cd_pending u_pend (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_v[g])
        );
    end

    assign cnt_irq  = pend_v[CH_CNT] && ctrl.ien;
    assign cnt_wake = pend_v[CH_CNT] && ctrl.wake_en;
    assign wall_irq = pend_v[CH_WALL] && ctrl.wall_ien;

    // R4
    fire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_v[CH_CNT]) |-> (remain == '0 || $past(load_req.load)));

    // R9
    wall_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_v[CH_WALL]) |-> $past(ctrl.wall_run));

endmodule

// File: tb/test_cd_alarm.sv
module test_cd_alarm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wall_match = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cnt_irq, cnt_wake, wall_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cd_alarm i_cd_alarm (
        .clk(clk), .rst(rst), .tick(tick), .wall_match(wall_match),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cnt_irq(cnt_irq), .cnt_wake(cnt_wake),
        .wall_irq(wall_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk("R1 reg reset", d, 32'd0);
        end
        chk("R1 irq reset", {29'd0, cnt_irq, cnt_wake, wall_irq}, 32'd0);
    endtask

    task automatic t_load;
        logic [31:0] d;
        wr(4'd0, 32'hDEAD_0010);
        rd(4'd1, d); chk("R2 remain after load", d, 32'hDEAD_0010);
        rd(4'd0, d); chk("R2 load readback", d, 32'hDEAD_0010);
    endtask

    task automatic t_count_gate;
        logic [31:0] d;
        wr(4'd0, 32'd20);
        ticks(3);
        rd(4'd1, d); chk("R3 no count while stopped", d, 32'd20);
        wr(4'd2, 32'd1);
        ticks(5);
        rd(4'd1, d); chk("R3 five ticks", d, 32'd15);
        wr(4'd2, 32'd0);
        ticks(2);
        rd(4'd1, d); chk("R3 hold after stop", d, 32'd15);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        wr(4'd3, 32'd1);
        wr(4'd5, 32'd0);
        wr(4'd0, 32'd3);
        wr(4'd2, 32'd1);
        ticks(2);
        rd(4'd4, d); chk("R4 not yet pending", d, 32'd0);
        chk("R7 irq low before expiry", {31'd0, cnt_irq}, 32'd0);
        ticks(1);
        rd(4'd1, d); chk("R4 reached zero", d, 32'd0);
        rd(4'd4, d); chk("R4 pending set", d, 32'd1);
        chk("R7 irq with enable", {31'd0, cnt_irq}, 32'd1);
        chk("R8 wake off without enable", {31'd0, cnt_wake}, 32'd0);
        ticks(3);
        rd(4'd1, d); chk("R4 stays at zero", d, 32'd0);
        wr(4'd4, 32'd0);
        rd(4'd4, d); chk("R6 write 0 keeps pending", d, 32'd1);
        wr(4'd4, 32'd1);
        rd(4'd4, d); chk("R6 write 1 clears", d, 32'd0);
        ticks(3);
        rd(4'd4, d); chk("R4 no second fire", d, 32'd0);
    endtask

    task automatic t_irq_wake;
        logic [31:0] d;
        wr(4'd3, 32'd0);
        wr(4'd5, 32'd1);
        wr(4'd0, 32'd1);
        ticks(1);
        rd(4'd4, d); chk("R4 pending from 1", d, 32'd1);
        chk("R7 irq masked", {31'd0, cnt_irq}, 32'd0);
        chk("R8 wake asserted", {31'd0, cnt_wake}, 32'd1);
        wr(4'd5, 32'd0);
        chk("R8 wake dropped by enable", {31'd0, cnt_wake}, 32'd0);
        wr(4'd3, 32'd1);
        chk("R7 irq follows enable", {31'd0, cnt_irq}, 32'd1);
        wr(4'd4, 32'd1);
        chk("R7 irq low after clear", {31'd0, cnt_irq}, 32'd0);
    endtask

    task automatic t_load_zero;
        logic [31:0] d;
        wr(4'd0, 32'd2);
        ticks(1);
        wr(4'd0, 32'd0);
        rd(4'd1, d); chk("R5 cancelled count", d, 32'd0);
        rd(4'd4, d); chk("R5 no pending on cancel", d, 32'd0);
        ticks(2);
        rd(4'd4, d); chk("R5 no pending later", d, 32'd0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(4'd0, 32'd1);
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        rd(4'd4, d); chk("R6 expiry beats clear", d, 32'd1);
        wr(4'd4, 32'd1);
        wr(4'd0, 32'd7);
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'd9;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        rd(4'd1, d); chk("R11 load beats tick", d, 32'd9);
    endtask

    task automatic t_wall;
        logic [31:0] d;
        @(negedge clk); wall_match = 1'b1;
        @(negedge clk); wall_match = 1'b0;
        rd(4'd8, d); chk("R9 match ignored when off", d, 32'd0);
        wr(4'd6, 32'd1);
        wr(4'd7, 32'd1);
        @(negedge clk); wall_match = 1'b1;
        @(negedge clk); wall_match = 1'b0;
        rd(4'd8, d); chk("R9 wall pending", d, 32'd1);
        chk("R9 wall irq", {31'd0, wall_irq}, 32'd1);
        wr(4'd8, 32'd1);
        rd(4'd8, d); chk("R9 wall cleared", d, 32'd0);
        chk("R9 wall irq low", {31'd0, wall_irq}, 32'd0);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(4'd2, 32'd0);
        wr(4'd0, 32'd44);
        wr(4'd1, 32'd5);
        rd(4'd1, d); chk("R10 remain read-only", d, 32'd44);
        rd(4'd12, d); chk("R10 unmapped reads 0", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_count_gate();
        t_expire();
        t_irq_wake();
        t_load_zero();
        t_collide();
        t_wall();
        t_readonly();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule